// File: doc/BRIEF.md
# Vertical Blank Interrupt Controller

This block raises the vertical-blank interrupt of a VGA-compatible display controller. It watches a one-cycle pulse that marks the start of vertical blank and snoops host writes to the CRTC index and data ports. From those it keeps an interrupt condition in one of three states: disarmed, idle (armed) or pending. A CRTC control register (index 0x11) arms and clears the condition. Two of its bits, together with a bus-dependent enable, gate a registered level interrupt line.

Host software sees the pending condition as bit 7 of input status register 0. The block merges that bit into the base status value supplied by the surrounding controller. An optional extended status bit flips on every read of its register, which gives polling software a sync indication that always changes. The CRTC index register is kept inside the block. Its width is chosen by a parameter: 7 bits for the newer variant and 6 bits for the older one.

Top module: `vblank_irq_ctrl`

## Requirements
- R1: After reset the condition is idle, `irq_line` is 0, `crtc_index` is 0, the stored control bits 4 and 5 are 0, and the toggle flag is 0.
- R2: On a cycle with `vblank_start` high, the condition becomes pending unless it is disarmed. A disarmed condition stays disarmed.
- R3: A data write while `crtc_index` equals 0x11 with data bit 4 clear moves pending to disarmed. An idle condition stays idle.
- R4: A data write while `crtc_index` equals 0x11 with data bit 4 set moves disarmed to idle. A pending condition stays pending.
- R5: `irq_line` is a register. At each clock edge it loads 1 exactly when all of these hold after that edge: the next condition is pending, stored bit 5 of register 0x11 is 0, stored bit 4 is 1, `bus_is_pci` is 1 and `gc_irq_en` is 1.
- R6: When `bus_is_pci` is 0, `irq_line` goes to 0 at the next edge and stays 0, whatever `gc_irq_en` and the condition are.
- R7: `stat0_q` equals `stat0_base` with bit 7 forced to 1 while the condition is pending, and equals `stat0_base` otherwise.
- R8: A write on `crtc_idx_wr` stores the low 7 bits of `wr_data` (6 bits on the older variant), and `crtc_index` shows them zero-extended. A data write reaches register 0x11 only when the stored index equals 0x11 exactly. For example, an index of 0x51 does not select it.
- R9: On a cycle with `ext_rd` high, the toggle flag inverts at the edge. `ext_stat_q` bit 7 shows the inverted value during that read, and all other bits of `ext_stat_q` are 0. With `ext_rd` low, bit 7 shows the stored flag.
- R10: When a 0x11 data write and `vblank_start` fall in the same cycle, the write is applied first and vblank second. So pending with bit 4 clear ends disarmed, and idle with bit 4 clear ends pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| vblank_start | input | 1 | One-cycle pulse marking the start of vertical blank |
| crtc_idx_wr | input | 1 | Host write strobe for the CRTC index port |
| crtc_data_wr | input | 1 | Host write strobe for the CRTC data port |
| wr_data | input | 8 | Host write data |
| bus_is_pci | input | 1 | 1 when the controller sits on a PCI bus |
| gc_irq_en | input | 1 | Interrupt enable bit from the graphics-controller register (used on PCI only) |
| stat0_base | input | 8 | Input status 0 value from the rest of the controller |
| stat0_q | output | 8 | Input status 0 read value with the pending bit merged in |
| ext_rd | input | 1 | Read strobe for the extended status register |
| ext_stat_q | output | 8 | Extended status read value; bit 7 is the toggle flag |
| crtc_index | output | 8 | Stored CRTC index, zero-extended |
| irq_line | output | 1 | Level interrupt request |

## Verification
The assertions assume that all inputs are synchronous to `clk`. They also assume that an index write and a data write never share a cycle, because the data write would then decode a stale index. The stimulus is driven at the falling edge and keeps the two strobes mutually exclusive, both in the scripted sequences and in the random phase. Within that limit, vblank pulses, control writes, bus-type changes and enable changes are free to collide, including the same-cycle write and vblank orderings of R10.

// File: rtl/vbi_pkg.sv
package vbi_pkg;
   typedef enum logic [1:0] {
      VB_DISARMED = 2'd0,
      VB_IDLE     = 2'd1,
      VB_PENDING  = 2'd2
   } vb_state_e;
endpackage

// File: rtl/vbi_index_reg.sv
module vbi_index_reg #(
   parameter int DATA_W = 8,
   parameter int IDX_W  = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              idx_wr,
   input  logic [DATA_W-1:0] wr_data,
   output logic [IDX_W-1:0]  index_q
);
   initial begin
      if (IDX_W < 1 || IDX_W > DATA_W) $error("index width out of range");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      index_q <= '0;
      else if (idx_wr) index_q <= wr_data[IDX_W-1:0];
   end

   // R8
   idx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !idx_wr |=> $stable(index_q));
endmodule

// File: rtl/vbi_state_fsm.sv
module vbi_state_fsm
   import vbi_pkg::*;
#(
   parameter int DATA_W   = 8,
   parameter int ARM_BIT  = 4,
   parameter int GATE_BIT = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              vblank,
   input  logic              ctl_wr,
   input  logic [DATA_W-1:0] wr_data,
   output vb_state_e         state_q,
   output vb_state_e         state_d,
   output logic              arm_d,
   output logic              gate_d
);
   logic arm_q, gate_q;

   initial begin
      if (ARM_BIT >= DATA_W || GATE_BIT >= DATA_W || ARM_BIT == GATE_BIT)
         $error("control bit positions invalid");
   end

   always_comb begin
      state_d = state_q;
      arm_d   = arm_q;
      gate_d  = gate_q;
      if (ctl_wr) begin
         arm_d  = wr_data[ARM_BIT];
         gate_d = wr_data[GATE_BIT];
         if (!wr_data[ARM_BIT] && state_q == VB_PENDING)
            state_d = VB_DISARMED;
         else if (wr_data[ARM_BIT] && state_q == VB_DISARMED)
            state_d = VB_IDLE;
      end
      if (vblank && state_d != VB_DISARMED)
         state_d = VB_PENDING;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= VB_IDLE;
         arm_q   <= 1'b0;
         gate_q  <= 1'b0;
      end else begin
         state_q <= state_d;
         arm_q   <= arm_d;
         gate_q  <= gate_d;
      end
   end

   // R2
   idle_to_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (vblank && state_q == VB_IDLE) |=> state_q == VB_PENDING);
   // R2
   disarm_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == VB_DISARMED && !(ctl_wr && wr_data[ARM_BIT])) |=> state_q == VB_DISARMED);
   // R3
   disarm_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_wr && !wr_data[ARM_BIT] && state_q == VB_PENDING) |=> state_q == VB_DISARMED);
   // R4
   rearm_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_wr && wr_data[ARM_BIT] && state_q == VB_DISARMED && !vblank) |=> state_q == VB_IDLE);
   // R4
   pend_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == VB_PENDING && !(ctl_wr && !wr_data[ARM_BIT])) |=> state_q == VB_PENDING);
endmodule

// File: rtl/vbi_sync_toggle.sv
module vbi_sync_toggle #(
   parameter bit TOGGLE_EN = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic rd,
   output logic rd_bit
);
   generate
      if (TOGGLE_EN) begin : g_toggle
         logic flag_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)  flag_q <= 1'b0;
            else if (rd) flag_q <= ~flag_q;
         end
         assign rd_bit = flag_q ^ rd;

         // R9
         flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
            rd |=> flag_q != $past(flag_q));
         // R9
         flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !rd |=> $stable(flag_q));
      end else begin : g_fixed
         assign rd_bit = 1'b0;
      end
   endgenerate
endmodule

// File: rtl/vblank_irq_ctrl.sv
module vblank_irq_ctrl
   import vbi_pkg::*;
#(
   parameter int   DATA_W     = 8,
   parameter bit   WIDE_INDEX = 1'b1,
   parameter int   CTL_INDEX  = 'h11,
   parameter int   ARM_BIT    = 4,
   parameter int   GATE_BIT   = 5,
   parameter int   PEND_BIT   = 7,
   parameter int   SYNC_BIT   = 7,
   parameter bit   TOGGLE_EN  = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              vblank_start,
   input  logic              crtc_idx_wr,
   input  logic              crtc_data_wr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              bus_is_pci,
   input  logic              gc_irq_en,
   input  logic [DATA_W-1:0] stat0_base,
   output logic [DATA_W-1:0] stat0_q,
   input  logic              ext_rd,
   output logic [DATA_W-1:0] ext_stat_q,
   output logic [DATA_W-1:0] crtc_index,
   output logic              irq_line
);
   localparam int IDX_W = WIDE_INDEX ? 7 : 6;

   initial begin
      if (DATA_W < 8) $error("data width too small");
      if (PEND_BIT >= DATA_W || SYNC_BIT >= DATA_W) $error("status bit out of range");
      if (CTL_INDEX >= (1 << IDX_W)) $error("control index not reachable");
   end

   logic [IDX_W-1:0] index_q;
   logic             ctl_wr, arm_d, gate_d, sync_bit, irq_en, irq_q;
   vb_state_e        state_q, state_d;

   vbi_index_reg #(.DATA_W(DATA_W), .IDX_W(IDX_W)) i_index (
      .clk(clk), .rst_n(rst_n), .idx_wr(crtc_idx_wr),
      .wr_data(wr_data), .index_q(index_q));

   assign ctl_wr = crtc_data_wr && (index_q == IDX_W'(CTL_INDEX));

   vbi_state_fsm #(.DATA_W(DATA_W), .ARM_BIT(ARM_BIT), .GATE_BIT(GATE_BIT)) i_fsm (
      .clk(clk), .rst_n(rst_n), .vblank(vblank_start), .ctl_wr(ctl_wr),
      .wr_data(wr_data), .state_q(state_q), .state_d(state_d),
      .arm_d(arm_d), .gate_d(gate_d));

   vbi_sync_toggle #(.TOGGLE_EN(TOGGLE_EN)) i_sync (
      .clk(clk), .rst_n(rst_n), .rd(ext_rd), .rd_bit(sync_bit));

   // only a PCI configuration ever drives the line; there the GC bit enables it
   assign irq_en = bus_is_pci && gc_irq_en;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) irq_q <= 1'b0;
      else        irq_q <= irq_en && (state_d == VB_PENDING) && arm_d && !gate_d;
   end

   assign irq_line   = irq_q;
   assign crtc_index = DATA_W'(index_q);

   always_comb begin
      stat0_q = stat0_base;
      if (state_q == VB_PENDING) stat0_q[PEND_BIT] = 1'b1;
      ext_stat_q = '0;
      ext_stat_q[SYNC_BIT] = sync_bit;
   end

   // R5
   irq_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq_line |-> state_q == VB_PENDING);
   // R6
   irq_pci_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_is_pci |=> !irq_line);
   // R5
   irq_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !gc_irq_en |=> !irq_line);
   // R7
   stat_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
      stat0_q[PEND_BIT] == (stat0_base[PEND_BIT] || (state_q == VB_PENDING)));
endmodule

// File: tb/test_vblank_irq_ctrl.sv
module test_vblank_irq_ctrl;
   localparam int CLK_PERIOD = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       vblank_start = 1'b0, crtc_idx_wr = 1'b0, crtc_data_wr = 1'b0;
   logic [7:0] wr_data = 8'h00;
   logic       bus_is_pci = 1'b1, gc_irq_en = 1'b1;
   logic [7:0] stat0_base = 8'h00;
   logic [7:0] stat0_q, ext_stat_q, crtc_index;
   logic       ext_rd = 1'b0;
   logic       irq_line;

   vblank_irq_ctrl i_vblank_irq_ctrl (
      .clk(clk), .rst_n(rst_n), .vblank_start(vblank_start),
      .crtc_idx_wr(crtc_idx_wr), .crtc_data_wr(crtc_data_wr), .wr_data(wr_data),
      .bus_is_pci(bus_is_pci), .gc_irq_en(gc_irq_en), .stat0_base(stat0_base),
      .stat0_q(stat0_q), .ext_rd(ext_rd), .ext_stat_q(ext_stat_q),
      .crtc_index(crtc_index), .irq_line(irq_line));

   always #(CLK_PERIOD/2) clk = ~clk;

   int    errors = 0, checks = 0;
   bit    done = 1'b0;
   string phase = "R1";

   // reference model: 0 disarmed, 1 idle, 2 pending
   int m_state = 1;
   bit m_arm = 0, m_gate = 0, m_irq = 0, m_flag = 0;
   int m_idx = 0;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_state = 1; m_arm = 0; m_gate = 0; m_irq = 0; m_flag = 0; m_idx = 0;
      end else begin
         int ns;
         ns = m_state;
         if (crtc_data_wr && m_idx == 'h11) begin
            m_arm  = wr_data[4];
            m_gate = wr_data[5];
            if (!wr_data[4] && ns == 2) ns = 0;
            else if (wr_data[4] && ns == 0) ns = 1;
         end
         if (vblank_start && ns != 0) ns = 2;
         m_state = ns;
         m_irq = bus_is_pci && gc_irq_en && ns == 2 && m_arm && !m_gate;
         if (crtc_idx_wr) m_idx = wr_data & 8'h7f;
         if (ext_rd) m_flag = !m_flag;
      end
   end

   task automatic chk(input string what, input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s [%s] %s actual=%0h expected=%0h at %0t", tag, phase, what, act, exp, $time);
      end
   endtask

   task automatic compare_all();
      int exp_stat, exp_ext;
      exp_stat = stat0_base | ((m_state == 2) ? 8'h80 : 8'h00);
      exp_ext  = (m_flag ^ ext_rd) ? 8'h80 : 8'h00;
      chk("irq_line",   "R5", irq_line,   m_irq);
      chk("stat0_q",    "R7", stat0_q,    exp_stat);
      chk("crtc_index", "R8", crtc_index, m_idx);
      chk("ext_stat_q", "R9", ext_stat_q, exp_ext);
   endtask

   // one cycle: compare what the current inputs produce, then drive the next set
   task automatic cyc(input bit vb, input bit iw, input bit dw, input logic [7:0] d, input bit er);
      @(negedge clk);
      #1;
      compare_all();
      vblank_start = vb; crtc_idx_wr = iw; crtc_data_wr = dw; wr_data = d; ext_rd = er;
   endtask

   task automatic idle_cyc(input int n);
      for (int i = 0; i < n; i++) cyc(0, 0, 0, 8'h00, 0);
   endtask

   initial begin
      // R1 reset values
      repeat (3) @(negedge clk);
      #1;
      chk("irq_line reset",   "R1", irq_line,   0);
      chk("crtc_index reset", "R1", crtc_index, 0);
      chk("stat0 reset",      "R1", stat0_q,    8'h00);
      chk("ext reset",        "R1", ext_stat_q, 8'h00);
      rst_n = 1'b1;
      idle_cyc(2);

      phase = "R2 arm and vblank";
      stat0_base = 8'h15;
      cyc(0, 1, 0, 8'h11, 0);
      cyc(0, 0, 1, 8'h10, 0);
      cyc(1, 0, 0, 8'h00, 0);
      idle_cyc(3);
      chk("irq asserted after vblank", "R5", irq_line, 1);
      chk("pending status bit", "R7", stat0_q, 8'h95);

      phase = "R4 gate bit set while pending";
      cyc(0, 0, 1, 8'h30, 0);
      idle_cyc(2);
      chk("irq gated by bit 5", "R5", irq_line, 0);
      chk("still pending", "R4", stat0_q[7], 1);
      cyc(0, 0, 1, 8'h10, 0);
      idle_cyc(2);

      phase = "R3 disarm";
      cyc(0, 0, 1, 8'h00, 0);
      idle_cyc(2);
      chk("disarmed clears status", "R3", stat0_q[7], 0);
      phase = "R2 vblank while disarmed";
      cyc(1, 0, 0, 8'h00, 0);
      idle_cyc(2);
      chk("disarmed ignores vblank", "R2", stat0_q[7], 0);

      phase = "R4 rearm";
      cyc(0, 0, 1, 8'h10, 0);
      idle_cyc(1);
      cyc(1, 0, 0, 8'h00, 0);
      idle_cyc(2);
      chk("rearmed pends", "R4", stat0_q[7], 1);

      phase = "R6 bus and enable gating";
      gc_irq_en = 1'b0;
      idle_cyc(2);
      chk("gc enable low", "R5", irq_line, 0);
      gc_irq_en = 1'b1; bus_is_pci = 1'b0;
      idle_cyc(2);
      chk("non-pci never drives", "R6", irq_line, 0);
      bus_is_pci = 1'b1;
      idle_cyc(2);

      phase = "R10 write and vblank together";
      cyc(1, 0, 1, 8'h00, 0);
      idle_cyc(2);
      chk("pending+clear+vblank ends disarmed", "R10", stat0_q[7], 0);
      cyc(0, 0, 1, 8'h10, 0);
      idle_cyc(1);
      cyc(1, 0, 1, 8'h00, 0);
      idle_cyc(2);
      chk("idle+clear+vblank ends pending", "R10", stat0_q[7], 1);

      phase = "R8 index width";
      cyc(0, 1, 0, 8'h51, 0);
      cyc(0, 0, 1, 8'h00, 0);
      idle_cyc(2);
      chk("index 0x51 kept", "R8", crtc_index, 8'h51);
      chk("0x51 does not hit 0x11", "R8", stat0_q[7], 1);
      cyc(0, 1, 0, 8'hff, 0);
      idle_cyc(2);
      chk("index masked to 7 bits", "R8", crtc_index, 8'h7f);

      phase = "R9 toggle";
      cyc(0, 0, 0, 8'h00, 1);
      cyc(0, 0, 0, 8'h00, 1);
      cyc(0, 0, 0, 8'h00, 0);
      cyc(0, 0, 0, 8'h00, 1);
      idle_cyc(2);

      phase = "random";
      for (int i = 0; i < 4000; i++) begin
         int r, k;
         logic [7:0] d;
         r = $urandom_range(0, 15);
         k = $urandom_range(0, 9);
         d = 8'($urandom);
         if ($urandom_range(0, 31) == 0) bus_is_pci = ~bus_is_pci;
         if ($urandom_range(0, 15) == 0) gc_irq_en = ~gc_irq_en;
         if ($urandom_range(0, 63) == 0) stat0_base = 8'($urandom);
         if (k == 0)      cyc(r < 4, 1, 0, ($urandom_range(0, 3) == 0) ? d : 8'h11, r[0]);
         else if (k < 4)  cyc(r < 4, 0, 1, d, r[1]);
         else             cyc(r < 3, 0, 0, d, r[2]);
      end
      idle_cyc(2);

      if (!done) begin
         done = 1'b1;
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         errors++;
         checks++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule